// File: doc/BRIEF.md
# Receive Byte Queue with Programmable Fill Alarm

This block buffers bytes from a smart-card serial receiver until the CPU reads them. The receiver datapath offers one byte per write strobe. The block keeps the byte only while the receive enable input is high. The CPU takes the oldest byte with a read strobe. The byte is presented on a registered output in the cycle after the strobe. Software can drain the queue at any time and does not need to stop reception first.

Two status outputs describe the fill state. The first is a data-present flag that shows at least one unread byte is held. The second is a fill alarm that compares the unread count with a programmable level. That compare is combinational, so a new level takes effect without any clock edge. The alarm can drive an interrupt unless the mask input is set. A byte that arrives while the queue is full is lost, and a sticky overflow error records the loss. Software clears the error by pulsing the clear input.

Top module: `rx_byte_queue`

## Requirements
- R1: After reset the queue is empty, dataPresent, threshHit, irqOut and overflowErr are 0, and rdData is 0x00.
- R2: A byte offered with wrValid is stored only when rxEnable is 1. With rxEnable at 0 the byte is discarded and the queue does not change.
- R3: The queue holds up to 32 bytes and returns them in arrival order. A rdStrobe while dataPresent is 1 places the oldest byte on rdData after the next clock edge.
- R4: dataPresent is 1 exactly when at least one unread byte is held. It never drives irqOut.
- R5: A rdStrobe while the queue is empty leaves rdData holding the byte from the previous read, and the unread count does not change.
- R6: For thresh values 1 to 31, threshHit is 1 when the unread count is at least thresh. A thresh value of 0 means 32, so threshHit needs a full queue.
- R7: threshHit follows a change of thresh combinationally, within the same cycle, so it can set or clear with no data moving.
- R8: irqOut equals threshHit when intMask is 0 and is 0 when intMask is 1.
- R9: A byte that arrives with all 32 entries full, and no read in the same cycle, is dropped. overflowErr is then 1 after that clock edge.
- R10: overflowErr stays set until a cycle with ovfClear at 1 and no new overflow. A new overflow in the same cycle as ovfClear wins, and the flag stays 1.
- R11: An accepted write and a read in the same cycle leave the count unchanged. This holds when the queue is full, and in that case the incoming byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxEnable | input | 1 | Reception enable |
| wrValid | input | 1 | Byte write strobe from the receiver datapath |
| wrData | input | 8 | Incoming byte |
| rdStrobe | input | 1 | CPU read strobe |
| rdData | output | 8 | Last byte read (registered) |
| thresh | input | 5 | Fill alarm level (0 means 32) |
| intMask | input | 1 | 1 blocks the fill alarm interrupt |
| ovfClear | input | 1 | Write-one-to-clear pulse for overflowErr |
| dataPresent | output | 1 | At least one unread byte |
| threshHit | output | 1 | Unread count at or above the alarm level |
| irqOut | output | 1 | Fill alarm interrupt request |
| overflowErr | output | 1 | Sticky flag for a byte lost to a full queue |

## Verification
A wrong pointer or count shows up at the ports very quickly. A count error changes dataPresent or threshHit in the cycle right after the bad update, and the bench checks every cycle. The bench compares threshHit against all 32 alarm levels at every fill level. That sweep exposes an off-by-one count within one sweep step. A pointer that slips, with the count still correct, shows up only when the bad entry is read, so it appears on rdData one cycle after the read of that byte. The bench drains the queue completely after each phase, so no such slip stays hidden.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Strobes that the control issues to the storage datapath
  typedef struct packed {
    logic push;  // write wrData at the write pointer
    logic pop;   // load the entry at the read pointer into rdData
  } rxqStrobes_t;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxEnable,
  input  logic             wrValid,
  input  logic             rdStrobe,
  input  logic             ovfClear,
  input  logic [PTR_W-1:0] thresh,
  input  logic             intMask,
  output rxqStrobes_t      strobes,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic             dataPresent,
  output logic             threshHit,
  output logic             irqOut,
  output logic             overflowErr
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] effThresh;
  logic             isEmpty, isFull, arrive, popOk, pushOk, lostByte;

  assign isEmpty  = (count == '0);
  assign isFull   = (count == FULL_CNT);
  assign arrive   = wrValid & rxEnable;
  assign popOk    = rdStrobe & ~isEmpty;
  // A read in the same cycle frees a slot, so a full queue still accepts
  assign pushOk   = arrive & (~isFull | popOk);
  assign lostByte = arrive & ~pushOk;

  assign strobes.push = pushOk;
  assign strobes.pop  = popOk;

  // Pointers wrap naturally: DEPTH must be a power of two
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= wrPtr + PTR_W'(1);
      if (popOk)  rdPtr <= rdPtr + PTR_W'(1);
      case ({pushOk, popOk})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         overflowErr <= 1'b0;
    else if (lostByte) overflowErr <= 1'b1;
    else if (ovfClear) overflowErr <= 1'b0;
  end

  // Level zero stands for a full queue; compare is purely combinational
  assign effThresh   = (thresh == '0) ? FULL_CNT : {1'b0, thresh};
  assign threshHit   = (count >= effThresh);
  assign dataPresent = ~isEmpty;
  assign irqOut      = threshHit & ~intMask;

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);
  assert_full_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (arrive && isFull && !rdStrobe) |=> (overflowErr && isFull));
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (overflowErr && !ovfClear) |=> overflowErr);
  assert_pair_keeps_count_R11: assert property (@(posedge clk) disable iff (!rstN)
    (pushOk && popOk) |=> $stable(count));
  assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    (isEmpty && rdStrobe && !arrive) |=> (isEmpty && $stable(rdPtr)));
endmodule

// File: rtl/rxq_data.sv
module rxq_data
  import rxq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxqStrobes_t      strobes,
  input  logic [PTR_W-1:0] wrPtr,
  input  logic [PTR_W-1:0] rdPtr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.push) store[wrPtr] <= wrData;
  end

  // Last-read register: holds its value when no entry is popped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (strobes.pop) rdData <= store[rdPtr];
  end

  assert_hold_on_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.pop |=> $stable(rdData));
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxEnable,
  input  logic             wrValid,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdStrobe,
  output logic [WIDTH-1:0] rdData,
  input  logic [PTR_W-1:0] thresh,
  input  logic             intMask,
  input  logic             ovfClear,
  output logic             dataPresent,
  output logic             threshHit,
  output logic             irqOut,
  output logic             overflowErr
);
  rxqStrobes_t      strobes;
  logic [PTR_W-1:0] wrPtr, rdPtr;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .wrValid(wrValid),
    .rdStrobe(rdStrobe), .ovfClear(ovfClear), .thresh(thresh),
    .intMask(intMask), .strobes(strobes), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .dataPresent(dataPresent), .threshHit(threshHit), .irqOut(irqOut),
    .overflowErr(overflowErr)
  );

  rxq_data #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrPtr(wrPtr),
    .rdPtr(rdPtr), .wrData(wrData), .rdData(rdData)
  );

  assert_alarm_needs_data_R6: assert property (@(posedge clk) disable iff (!rstN)
    threshHit |-> dataPresent);
  assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    intMask |-> !irqOut);
  assert_present_no_irq_R4: assert property (@(posedge clk) disable iff (!rstN)
    (dataPresent && !threshHit) |-> !irqOut);
endmodule

// File: tb/tb_rx_byte_queue.sv
`timescale 1ns/1ps
module tb_rx_byte_queue;
  localparam int DEPTH = 32;

  logic       clk = 0, rstN = 0;
  logic       rxEnable = 0, wrValid = 0, rdStrobe = 0, intMask = 0, ovfClear = 0;
  logic [7:0] wrData = 0;
  logic [4:0] thresh = 5'd1;
  logic [7:0] rdData;
  logic       dataPresent, threshHit, irqOut, overflowErr;

  int checks = 0, errors = 0;
  byte unsigned mq[$];
  logic [7:0] expRd = 0;
  logic       expOvf = 0;
  logic [7:0] seed = 8'h11;

  always #2 clk = ~clk;

  rx_byte_queue dut (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .wrValid(wrValid),
    .wrData(wrData), .rdStrobe(rdStrobe), .rdData(rdData), .thresh(thresh),
    .intMask(intMask), .ovfClear(ovfClear), .dataPresent(dataPresent),
    .threshHit(threshHit), .irqOut(irqOut), .overflowErr(overflowErr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  function automatic logic expHit(input int cnt, input int lvl);
    return cnt >= ((lvl == 0) ? DEPTH : lvl);
  endfunction

  task automatic checkAll(input string tag);
    check({tag, " rdData R3"}, rdData, expRd);
    check({tag, " dataPresent R4"}, dataPresent, mq.size() > 0);
    check({tag, " threshHit R6"}, threshHit, expHit(mq.size(), thresh));
    check({tag, " irqOut R8"}, irqOut, expHit(mq.size(), thresh) & ~intMask);
    check({tag, " overflowErr R9"}, overflowErr, expOvf);
  endtask

  // One clock: drive at negedge, update model at posedge, sample 1 ns later
  task automatic cycle(input logic en, input logic w, input logic [7:0] d,
                       input logic r, input logic clr, input string tag);
    logic popOk, pushOk;
    rxEnable = en; wrValid = w; wrData = d; rdStrobe = r; ovfClear = clr;
    @(posedge clk);
    popOk  = r && (mq.size() > 0);
    pushOk = w && en && ((mq.size() < DEPTH) || popOk);
    if (popOk) expRd = mq.pop_front();
    if (pushOk) mq.push_back(d);
    if (w && en && !pushOk) expOvf = 1;
    else if (clr) expOvf = 0;
    #1;
    checkAll(tag);
    @(negedge clk);
    wrValid = 0; rdStrobe = 0; ovfClear = 0;
  endtask

  function automatic logic [7:0] nextByte();
    seed = {seed[6:0], seed[7] ^ seed[5] ^ seed[4] ^ seed[3]};
    return seed;
  endfunction

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1; checkAll("R1 reset");
    rstN = 1;
    @(negedge clk);

    // R2: writes with reception disabled are discarded
    for (int i = 0; i < 4; i++) cycle(0, 1, 8'hA0 + 8'(i), 0, 0, "R2 disabled");

    // R6/R7/R8: fill one at a time, sweep every level combinationally
    for (int fill = 0; fill <= DEPTH; fill++) begin
      if (fill > 0) cycle(1, 1, nextByte(), 0, 0, "R3 fill");
      for (int lvl = 0; lvl < 32; lvl++) begin
        thresh = 5'(lvl);
        for (int m = 0; m < 2; m++) begin
          intMask = m[0];
          #0.1;
          check("R7 threshHit", threshHit, expHit(fill, lvl));
          check("R8 irqOut", irqOut, expHit(fill, lvl) & ~m[0]);
        end
      end
      intMask = 0;
      thresh = 5'd1;
      @(negedge clk);
    end

    // R9: arrival at full with no read is lost, flag sticks
    cycle(1, 1, 8'hEE, 0, 0, "R9 overflow");
    cycle(1, 0, 8'h00, 0, 0, "R10 sticky");
    // R11: write+read at full keeps count and keeps the byte
    cycle(1, 1, 8'h5C, 1, 0, "R11 full pair");
    // R10: set beats clear in the same cycle
    cycle(1, 1, 8'h77, 0, 1, "R10 set wins");
    cycle(1, 0, 8'h00, 0, 1, "R10 clear");

    // R3: drain fully in arrival order
    while (mq.size() > 0) cycle(1, 0, 8'h00, 1, 0, "R3 drain");
    // R5: empty reads hold last byte and count
    for (int i = 0; i < 3; i++) cycle(1, 0, 8'h00, 1, 0, "R5 empty read");
    cycle(1, 1, 8'h3D, 0, 0, "R5 after empty");
    cycle(1, 0, 8'h00, 1, 0, "R5 read back");

    // R11: paired traffic at mid fill, R2 toggle mid-stream
    for (int i = 0; i < 5; i++) cycle(1, 1, nextByte(), 0, 0, "R11 prefill");
    for (int i = 0; i < 20; i++)
      cycle(i[0], 1, nextByte(), 1, 0, "R11 pair");
    while (mq.size() > 0) cycle(1, 0, 8'h00, 1, 0, "R3 final drain");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule